// File: doc/BRIEF.md
# Per-Instruction Delta Correlation Prefetcher

The block watches the stream of cache misses leaving a cache controller. Each miss carries the program counter of the load or store that missed and the cache-line address it wanted. Every accepted miss is written into a shared circular history buffer in arrival order. An index table, selected by the low bits of the program counter and guarded by a tag, remembers the newest history entry for each instruction, and each new entry is linked back to the previous entry of the same instruction. This recovers one ordered stream per instruction from a single global log.

When a miss belongs to a known stream, the block walks that stream backwards over several cycles, collects up to a bounded number of line addresses and forms the line-address differences between neighbours. If the two newest differences reappear as a consecutive pair earlier in the same stream, the differences that came after that earlier pair are replayed, starting from the newest line, to produce a fixed number of prefetch line addresses on a valid/ready output. While a walk or a prefetch burst is in progress, new misses are held off with backpressure.

Top module: `miss_delta_pf`

## Requirements
- R1: After reset `miss_ready_o` is 1 and `pf_valid_o` is 0.
- R2: Predictions for one program counter use only that counter's misses; misses of other counters interleaved between them neither create nor disturb its prediction.
- R3: A history entry is overwritten after 2^HB_AW later misses; a stream link that points at an overwritten slot ends the stream, so no prediction is made until four new misses of that counter rebuild it.
- R4: A prediction is made only when the two newest deltas of the stream (newest line minus previous, previous minus the one before) equal a consecutive delta pair found earlier in the same stream; a constant stride therefore predicts from the fourth miss on, never earlier.
- R5: On a match, the most recent earlier matching pair is used; the deltas that followed it are replayed in time order, repeating that period, and prefetch j is the newest line plus the sum of the first j replayed deltas, for exactly PF_DEG prefetches.
- R6: The index table holds one stream per slot (slot = low IT_AW PC bits, tag = remaining bits); a miss whose tag differs from the stored one starts a new stream, issues no prefetch, and the old stream cannot be reached again.
- R7: A walk reads at most WALK_D entries; a delta pattern whose period needs more entries than that to match is never predicted.
- R8: After a miss that hits the index table is accepted, `miss_ready_o` is 0 in the next cycle and stays 0 until the walk and any prefetch burst have ended; no miss is accepted meanwhile.
- R9: While `pf_valid_o` is 1 and `pf_ready_i` is 0, `pf_valid_o` stays 1 and `pf_line_o` holds its value.
- R10: A miss that starts a new stream leaves `miss_ready_o` at 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A miss is offered |
| miss_ready_o | output | 1 | The block can accept a miss this cycle |
| miss_pc_i | input | PC_W | Program counter of the missing instruction |
| miss_line_i | input | LINE_W | Cache-line address of the miss |
| pf_valid_o | output | 1 | A prefetch line address is offered |
| pf_ready_i | input | 1 | The consumer takes the prefetch this cycle |
| pf_line_o | output | LINE_W | Prefetch cache-line address |

## Verification
The two activities that meet in one cycle are the hand-over of the final prefetch of a burst and a new miss already waiting at the input. The bench holds a miss on the input while the prefetch consumer stalls, then releases the consumer and samples every following cycle, expecting the burst lines one per cycle with the miss still refused, and `miss_ready_o` rising exactly in the cycle after the last prefetch leaves. A second overlap, writing a new miss into a slot that an older stream still links to, is provoked by flooding the buffer with another counter's misses and judged by the absence of any prediction until the stream is rebuilt.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_MATCH,
    ST_ISSUE
  } mdp_state_e;
endpackage

// File: rtl/mdp_index_table.sv
module mdp_index_table #(
  parameter int PC_W  = 32,
  parameter int IT_AW = 3,
  parameter int SEQ_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             lk_hit_o,
  output logic [SEQ_W-1:0] lk_seq_o,
  input  logic             wr_en_i,
  input  logic [SEQ_W-1:0] wr_seq_i
);
  localparam int ENTRIES = 1 << IT_AW;
  localparam int TAG_W   = PC_W - IT_AW;

  logic [ENTRIES-1:0]   vld_q;
  logic [TAG_W-1:0]     tag_q [ENTRIES];
  logic [SEQ_W-1:0]     seq_q [ENTRIES];
  logic [IT_AW-1:0]     idx;
  logic [TAG_W-1:0]     tag;

  assign idx      = lk_pc_i[IT_AW-1:0];
  assign tag      = lk_pc_i[PC_W-1:IT_AW];
  assign lk_hit_o = vld_q[idx] && (tag_q[idx] == tag);
  assign lk_seq_o = seq_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx] <= tag;
      seq_q[idx] <= wr_seq_i;
    end
  end

  // R6: the slot now belongs to the requesting counter
  a_r6_slot_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(idx)] && (tag_q[$past(idx)] == $past(tag))));
endmodule

// File: rtl/mdp_history_buf.sv
module mdp_history_buf #(
  parameter int LINE_W = 32,
  parameter int HB_AW  = 4,
  parameter int SEQ_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              wr_has_link_i,
  input  logic [SEQ_W-1:0]  wr_link_i,
  output logic [SEQ_W-1:0]  head_seq_o,
  input  logic [SEQ_W-1:0]  rd_seq_i,
  output logic              rd_ok_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic              rd_has_link_o,
  output logic [SEQ_W-1:0]  rd_link_o
);
  localparam int DEPTH = 1 << HB_AW;

  logic [DEPTH-1:0]  vld_q;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0]  has_q;
  logic [SEQ_W-1:0]  link_q [DEPTH];
  logic [SEQ_W-1:0]  head_q;
  logic [HB_AW-1:0]  wr_idx;
  logic [HB_AW-1:0]  rd_idx;

  assign wr_idx     = head_q[HB_AW-1:0];
  assign rd_idx     = rd_seq_i[HB_AW-1:0];
  assign head_seq_o = head_q;

  // an entry is live only while its slot still carries the same sequence number
  assign rd_ok_o       = vld_q[rd_idx] && (seq_q[rd_idx] == rd_seq_i);
  assign rd_line_o     = line_q[rd_idx];
  assign rd_has_link_o = has_q[rd_idx];
  assign rd_link_o     = link_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      head_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx] <= 1'b1;
      head_q        <= head_q + SEQ_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      seq_q[wr_idx]  <= head_q;
      line_q[wr_idx] <= wr_line_i;
      has_q[wr_idx]  <= wr_has_link_i;
      link_q[wr_idx] <= wr_link_i;
    end
  end

  // R3: each accepted miss lands in the slot named by its sequence number
  a_r3_slot_stamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx)] && (seq_q[$past(wr_idx)] == $past(head_q))));
endmodule

// File: rtl/mdp_delta_match.sv
module mdp_delta_match #(
  parameter int LINE_W = 32,
  parameter int WALK_D = 8,
  parameter int CNT_W  = 4,
  parameter int K_W    = 3
) (
  input  logic [WALK_D-1:0][LINE_W-1:0] lines_i,
  input  logic [CNT_W-1:0]              cnt_i,
  output logic                          found_o,
  output logic [K_W-1:0]                k_o,
  output logic [WALK_D-2:0][LINE_W-1:0] deltas_o
);
  // deltas_o[0] is the newest difference
  for (genvar g = 0; g < WALK_D - 1; g++) begin : g_delta
    assign deltas_o[g] = lines_i[g] - lines_i[g+1];
  end

  // search oldest to newest so the most recent match wins
  always_comb begin
    found_o = 1'b0;
    k_o     = '0;
    for (int j = WALK_D - 3; j >= 1; j--) begin
      if (((j + 2) < int'(cnt_i)) &&
          (deltas_o[j] == deltas_o[0]) && (deltas_o[j+1] == deltas_o[1])) begin
        found_o = 1'b1;
        k_o     = K_W'(j);
      end
    end
  end
endmodule

// File: rtl/miss_delta_pf.sv
module miss_delta_pf
  import mdp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int LINE_W = 32,
  parameter int IT_AW  = 3,
  parameter int HB_AW  = 4,
  parameter int SEQ_W  = 12,
  parameter int WALK_D = 8,
  parameter int PF_DEG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [PC_W-1:0]   miss_pc_i,
  input  logic [LINE_W-1:0] miss_line_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [LINE_W-1:0] pf_line_o
);
  localparam int CNT_W  = $clog2(WALK_D + 1);
  localparam int K_W    = $clog2(WALK_D);
  localparam int ISS_W  = $clog2(PF_DEG + 1);
  localparam logic [CNT_W-1:0] WALK_LAST = CNT_W'(WALK_D - 1);
  localparam logic [ISS_W-1:0] ISS_LAST  = ISS_W'(PF_DEG - 1);

  mdp_state_e                  state_q;
  logic [SEQ_W-1:0]            cur_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [WALK_D-1:0][LINE_W-1:0] walk_buf_q;
  logic [K_W-1:0]              k_q;
  logic [K_W-1:0]              pos_q;
  logic [K_W-1:0]              pos_nxt;
  logic [ISS_W-1:0]            issued_q;
  logic [LINE_W-1:0]           pf_addr_q;

  logic                        accept;
  logic                        it_hit;
  logic [SEQ_W-1:0]            it_seq;
  logic [SEQ_W-1:0]            hb_head;
  logic                        hb_rd_ok;
  logic [LINE_W-1:0]           hb_rd_line;
  logic                        hb_rd_has;
  logic [SEQ_W-1:0]            hb_rd_link;
  logic                        pm_found;
  logic [K_W-1:0]              pm_k;
  logic [WALK_D-2:0][LINE_W-1:0] pm_deltas;

  assign miss_ready_o = (state_q == ST_IDLE);
  assign accept       = miss_valid_i && miss_ready_o;
  assign pf_valid_o   = (state_q == ST_ISSUE);
  assign pf_line_o    = pf_addr_q;
  assign pos_nxt      = (pos_q == '0) ? (k_q - K_W'(1)) : (pos_q - K_W'(1));

  mdp_index_table #(.PC_W(PC_W), .IT_AW(IT_AW), .SEQ_W(SEQ_W)) u_index (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_pc_i  (miss_pc_i),
    .lk_hit_o (it_hit),
    .lk_seq_o (it_seq),
    .wr_en_i  (accept),
    .wr_seq_i (hb_head)
  );

  mdp_history_buf #(.LINE_W(LINE_W), .HB_AW(HB_AW), .SEQ_W(SEQ_W)) u_hist (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (accept),
    .wr_line_i     (miss_line_i),
    .wr_has_link_i (it_hit),
    .wr_link_i     (it_seq),
    .head_seq_o    (hb_head),
    .rd_seq_i      (cur_q),
    .rd_ok_o       (hb_rd_ok),
    .rd_line_o     (hb_rd_line),
    .rd_has_link_o (hb_rd_has),
    .rd_link_o     (hb_rd_link)
  );

  mdp_delta_match #(.LINE_W(LINE_W), .WALK_D(WALK_D), .CNT_W(CNT_W), .K_W(K_W)) u_match (
    .lines_i  (walk_buf_q),
    .cnt_i    (cnt_q),
    .found_o  (pm_found),
    .k_o      (pm_k),
    .deltas_o (pm_deltas)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      cnt_q      <= '0;
      walk_buf_q <= '0;
      k_q        <= '0;
      pos_q      <= '0;
      issued_q   <= '0;
      pf_addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // a new stream has nothing to walk
          if (accept && it_hit) begin
            state_q <= ST_WALK;
            cur_q   <= hb_head;
            cnt_q   <= '0;
          end
        end
        ST_WALK: begin
          if (hb_rd_ok) begin
            walk_buf_q[cnt_q[K_W-1:0]] <= hb_rd_line;
            cnt_q <= cnt_q + CNT_W'(1);
          end
          if (hb_rd_ok && hb_rd_has && (cnt_q < WALK_LAST)) cur_q <= hb_rd_link;
          else state_q <= ST_MATCH;
        end
        ST_MATCH: begin
          if (pm_found) begin
            state_q   <= ST_ISSUE;
            k_q       <= pm_k;
            pos_q     <= pm_k - K_W'(1);
            pf_addr_q <= walk_buf_q[0] + pm_deltas[pm_k - K_W'(1)];
            issued_q  <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          if (pf_ready_i) begin
            if (issued_q == ISS_LAST) begin
              state_q <= ST_IDLE;
            end else begin
              issued_q  <= issued_q + ISS_W'(1);
              pos_q     <= pos_nxt;
              pf_addr_q <= pf_addr_q + pm_deltas[pos_nxt];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: a miss that joins a known stream blocks the input next cycle
  a_r8_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o && it_hit) |=> !miss_ready_o);

  // R9: a stalled prefetch keeps its address
  a_r9_pf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_line_o)));

  // R5: burst ends after the last accepted prefetch
  a_r5_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && pf_ready_i && (issued_q == ISS_LAST)) |=> !pf_valid_o);

  // R4: a match needs an earlier pair fully inside the collected stream
  a_r4_match_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_MATCH) && pm_found) |->
      ((pm_k != '0) && ((CNT_W'(pm_k) + CNT_W'(2)) < cnt_q)));

  // R3: the walk starts at the entry just written
  a_r3_walk_head_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WALK) && (cnt_q == '0)) |-> hb_rd_ok);

  // R7: the walk never collects more than WALK_D lines
  a_r7_walk_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK) |-> (cnt_q < CNT_W'(WALK_D)));
endmodule

// File: tb/miss_delta_pf_test.sv
`timescale 1ns/1ps
module miss_delta_pf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_pc = '0;
  logic [31:0] miss_line = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_line;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] pf_log [64];
  int pf_n = 0;

  always #2 clk = ~clk;

  miss_delta_pf uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .miss_valid_i (miss_valid),
    .miss_ready_o (miss_ready),
    .miss_pc_i    (miss_pc),
    .miss_line_i  (miss_line),
    .pf_valid_o   (pf_valid),
    .pf_ready_i   (pf_ready),
    .pf_line_o    (pf_line)
  );

  always begin
    @(negedge clk);
    #1;
    if (rst_n && pf_valid && pf_ready) begin
      if (pf_n < 64) pf_log[pf_n] = pf_line;
      pf_n++;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_miss(input logic [31:0] pc, input logic [31:0] line);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_pc    = pc;
    miss_line  = line;
    #1;
    while (!miss_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    #1;
    while (!miss_ready && t < 200) begin
      @(negedge clk);
      #1;
      t++;
    end
  endtask

  task automatic miss(input logic [31:0] pc, input logic [31:0] line);
    send_miss(pc, line);
    wait_idle();
  endtask

  task automatic expect_pf(input string req, input int n,
                           input logic [31:0] e0, input logic [31:0] e1,
                           input logic [31:0] e2, input logic [31:0] e3);
    logic [31:0] e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(pf_n == n, req, "prefetch count", pf_n, n);
    for (int i = 0; i < n && i < 4 && i < pf_n; i++)
      chk(pf_log[i] == e[i], req, "prefetch line", pf_log[i], e[i]);
    pf_n = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(miss_ready == 1'b1, "R1", "miss_ready after reset", miss_ready, 1);
    chk(pf_valid == 1'b0, "R1", "pf_valid after reset", pf_valid, 0);
  endtask

  task automatic t_stride();
    miss(32'h401, 100);
    miss(32'h401, 104);
    miss(32'h401, 108);
    expect_pf("R4", 0, 0, 0, 0, 0);
    send_miss(32'h401, 112);
    #1;
    chk(miss_ready == 1'b0, "R8", "ready during walk", miss_ready, 0);
    wait_idle();
    expect_pf("R5", 4, 116, 120, 124, 128);
  endtask

  task automatic t_pattern();
    miss(32'h402, 0);
    miss(32'h402, 1);
    miss(32'h402, 3);
    miss(32'h402, 6);
    miss(32'h402, 7);
    expect_pf("R4", 0, 0, 0, 0, 0);
    miss(32'h402, 9);
    expect_pf("R5", 4, 12, 13, 15, 18);
  endtask

  task automatic t_interleave();
    miss(32'h403, 1000);
    miss(32'h404, 7000);
    miss(32'h403, 1002);
    miss(32'h404, 7005);
    miss(32'h403, 1004);
    miss(32'h404, 7030);
    expect_pf("R2", 0, 0, 0, 0, 0);
    miss(32'h403, 1006);
    expect_pf("R2", 4, 1008, 1010, 1012, 1014);
    miss(32'h404, 7031);
    expect_pf("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic t_alias();
    miss(32'h105, 300);
    miss(32'h105, 310);
    miss(32'h105, 320);
    miss(32'h105, 330);
    expect_pf("R6", 4, 340, 350, 360, 370);
    send_miss(32'h205, 900);
    #1;
    chk(miss_ready == 1'b1, "R10", "ready after new stream", miss_ready, 1);
    wait_idle();
    expect_pf("R6", 0, 0, 0, 0, 0);
    miss(32'h105, 340);
    miss(32'h105, 350);
    miss(32'h105, 360);
    expect_pf("R6", 0, 0, 0, 0, 0);
    miss(32'h105, 370);
    expect_pf("R6", 4, 380, 390, 400, 410);
  endtask

  task automatic t_overwrite();
    miss(32'h406, 200);
    miss(32'h406, 201);
    miss(32'h406, 202);
    expect_pf("R3", 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) miss(32'h407, 32'(5000 + i * i));
    expect_pf("R4", 0, 0, 0, 0, 0);
    miss(32'h406, 203);
    miss(32'h406, 204);
    miss(32'h406, 205);
    expect_pf("R3", 0, 0, 0, 0, 0);
    miss(32'h406, 206);
    expect_pf("R3", 4, 207, 208, 209, 210);
  endtask

  task automatic t_depth();
    logic [31:0] ln;
    ln = 20000;
    for (int i = 0; i < 20; i++) begin
      miss(32'h400, ln);
      ln = ln + 32'((i % 6) + 1);
    end
    expect_pf("R7", 0, 0, 0, 0, 0);
    ln = 30000;
    for (int i = 0; i < 6; i++) begin
      miss(32'h40C, ln);
      ln = ln + 32'((i % 4) + 1);
    end
    expect_pf("R7", 0, 0, 0, 0, 0);
    miss(32'h40C, ln);
    expect_pf("R7", 4, 30016, 30020, 30021, 30023);
  endtask

  task automatic t_backpressure();
    int t;
    miss(32'h40A, 500);
    miss(32'h40A, 503);
    miss(32'h40A, 506);
    expect_pf("R4", 0, 0, 0, 0, 0);
    @(negedge clk);
    pf_ready = 1'b0;
    send_miss(32'h40A, 509);
    t = 0;
    #1;
    while (!pf_valid && t < 50) begin
      @(negedge clk);
      #1;
      t++;
    end
    chk(pf_valid == 1'b1, "R9", "burst started", pf_valid, 1);
    chk(pf_line == 512, "R9", "first line", pf_line, 512);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_pc    = 32'h40B;
    miss_line  = 777;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(pf_valid == 1'b1 && pf_line == 512, "R9", "held line", pf_line, 512);
      chk(miss_ready == 1'b0, "R8", "miss refused while stalled", miss_ready, 0);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      if (c < 4) begin
        chk(pf_valid == 1'b1, "R5", "burst valid", pf_valid, 1);
        chk(pf_line == 32'(512 + 3 * c), "R5", "burst line", pf_line, 512 + 3 * c);
        chk(miss_ready == 1'b0, "R8", "miss refused in burst", miss_ready, 0);
      end else begin
        chk(pf_valid == 1'b0, "R5", "burst over", pf_valid, 0);
        chk(miss_ready == 1'b1, "R8", "ready after last prefetch", miss_ready, 1);
      end
      @(negedge clk);
    end
    miss_valid = 1'b0;
    wait_idle();
    pf_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stride();
    t_pattern();
    t_interleave();
    t_alias();
    t_overwrite();
    t_depth();
    t_backpressure();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule